// File: doc/BRIEF.md
# Codec Power Sequencer Register

This block keeps the power-control byte of a stereo audio codec and turns it into one enable line per analog block: the reference-voltage generator, the auxiliary mono input, the speaker driver, the line driver, the DAC and the left ADC/microphone path. A host writes the byte through a plain address, data and strobe port. The stored value is always visible on a read-back output.

Turning on the ADC path starts a warm-up countdown that runs on sample-rate ticks. ADC samples are marked valid only after the countdown ends. The reference generator is guarded: a write may switch it off only once nothing else that needs it is still powered. An invalid attempt leaves the reference on and raises a sticky error.

An active-low power-down pin overrides everything. While it is low, all enables drop at once and the byte returns to zero. A separate status output reports full power-down: all six bits are clear here, and the rest of the chip reports no powered block.

Top module: `codec_pwr_ctrl`

## Requirements
- R1: When power-down is released, the read-back byte is 0x00, every enable is 0, `adc_valid` is 0 and `cfg_err` is 0.
- R2: A strobed write to address 0x00 updates the byte on the next clock edge. Bit 6 drives `en_ref`, bit 5 `en_mono`, bit 4 `en_spk`, bit 3 `en_line`, bit 2 `en_dac` and bit 0 `en_adc`, with a 1 meaning powered.
- R3: A write to any address other than 0x00 leaves the byte and all outputs unchanged.
- R4: Bits 7 and 1 cannot be written and always read back as 0.
- R5: While `pdn_n` is low, every enable output is 0 without waiting for a clock. The byte is cleared and stays cleared after `pdn_n` returns high.
- R6: A write that clears bit 6 while bit 6 is set is refused if any other bit of the written value is 1 or `ext_pwr_on` is 1. Bit 6 stays 1, the other bits take the written value, and `cfg_err` goes to 1 and stays there until power-down.
- R7: A write that clears bit 6 while the written value's other bits are 0 and `ext_pwr_on` is 0 is honoured.
- R8: A write that moves bit 0 from 0 to 1 starts a warm-up of INIT_TICKS sample ticks (1059 by default). `adc_valid` is 0 until the clock edge that takes the last tick, and 1 from then on.
- R9: Clearing bit 0 drops `adc_valid` on the next edge. Setting bit 0 again restarts the full warm-up, whatever was left of the previous one.
- R10: Writing 1 to bit 0 while it is already 1 neither restarts the warm-up nor disturbs `adc_valid`.
- R11: `full_pd` is 1 exactly when `pdn_n` is low, or when all six power bits are 0 and `ext_pwr_on` is 0. This condition does not alter the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pdn_n | input | 1 | Active-low power-down; clears the byte, forces enables off |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| ext_pwr_on | input | 1 | High when another power bit, the PLL or the clock output is on elsewhere |
| fs_tick | input | 1 | One-cycle pulse per audio sample period |
| rd_data | output | 8 | Stored power byte |
| en_ref | output | 1 | Reference generator enable |
| en_mono | output | 1 | Mono auxiliary input enable |
| en_spk | output | 1 | Speaker driver enable |
| en_line | output | 1 | Line driver enable |
| en_dac | output | 1 | DAC enable |
| en_adc | output | 1 | Left ADC/microphone enable |
| adc_valid | output | 1 | ADC data may be used |
| cfg_err | output | 1 | Sticky flag for a refused reference clear |
| full_pd | output | 1 | Whole device is in power-down |

## Verification
The writes cover a single reference bit, an all-ones byte, a write to a foreign address, and two reference-clear attempts that have different blockers. Between them, these separate the write mask, the address decode, and the two sources that can hold the reference on. The warm-up is run three ways. The first is an uninterrupted run, checked just before and just after the tick count. The second re-enables the ADC partway through, which shows that the count restarts rather than resumes. The third rewrites bit 0 while it is already set, which shows that an idle rewrite does not retrigger. A behavioural model of the byte, the error flag and the tick count is compared with every output on every cycle. A power-down pulse is sampled between clock edges to show the immediate override.

// File: rtl/cpwr_pkg.sv
package cpwr_pkg;
   localparam int BYTE_W = 8;
   localparam int N_BLK  = 6;
   // bit positions inside the power byte
   localparam int B_ADC  = 0;
   localparam int B_DAC  = 2;
   localparam int B_LINE = 3;
   localparam int B_SPK  = 4;
   localparam int B_MONO = 5;
   localparam int B_REF  = 6;
   localparam logic [BYTE_W-1:0] WR_MASK     = 8'h7D;
   localparam logic [BYTE_W-1:0] NONREF_MASK = 8'h3D;

   // enable bus order: adc, dac, line, spk, mono, ref
   function automatic logic [N_BLK-1:0] to_en_bus(input logic [BYTE_W-1:0] r);
      return {r[B_REF], r[B_MONO], r[B_SPK], r[B_LINE], r[B_DAC], r[B_ADC]};
   endfunction
endpackage

// File: rtl/cpwr_regbank.sv
module cpwr_regbank
   import cpwr_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int REG_ADDR  = 0,
   parameter bit ASYNC_PDN = 1'b1
) (
   input  logic              clk,
   input  logic              pdn_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              ext_on,
   output logic [BYTE_W-1:0] reg_q,
   output logic              err_q,
   output logic              adc_start
);
   if (ADDR_W < 1) begin : g_bad_addr
      $error("cpwr_regbank: ADDR_W must be at least 1");
   end
   if (REG_ADDR < 0 || REG_ADDR >= (1 << ADDR_W)) begin : g_bad_reg
      $error("cpwr_regbank: REG_ADDR outside address space");
   end

   logic              hit;
   logic [BYTE_W-1:0] cand;
   logic              refuse;
   logic [BYTE_W-1:0] nxt;

   always_comb begin
      hit    = wr_en && (wr_addr == ADDR_W'(REG_ADDR));
      cand   = wr_data & WR_MASK;
      refuse = reg_q[B_REF] && !cand[B_REF] && ((|(cand & NONREF_MASK)) || ext_on);
      nxt    = cand;
      if (refuse) nxt[B_REF] = 1'b1;
      adc_start = hit && cand[B_ADC] && !reg_q[B_ADC];
   end

   if (ASYNC_PDN) begin : g_async
      always_ff @(posedge clk or negedge pdn_n) begin
         if (!pdn_n) begin
            reg_q <= '0;
            err_q <= 1'b0;
         end else begin
            if (hit) reg_q <= nxt;
            if (hit && refuse) err_q <= 1'b1;
         end
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!pdn_n) begin
            reg_q <= '0;
            err_q <= 1'b0;
         end else begin
            if (hit) reg_q <= nxt;
            if (hit && refuse) err_q <= 1'b1;
         end
      end
   end

   // R6: the reference stays on while another part of the chip needs it
   assert_ref_kept_R6: assert property (@(posedge clk) disable iff (!pdn_n)
      (reg_q[B_REF] && ext_on) |=> reg_q[B_REF]);
   // R6: the error flag is sticky
   assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!pdn_n)
      err_q |=> err_q);
   // R6: an error only comes with a held reference
   assert_err_ref_R6: assert property (@(posedge clk) disable iff (!pdn_n)
      $rose(err_q) |-> reg_q[B_REF]);
   // R7: the reference only falls when no outside block was on
   assert_ref_clear_R7: assert property (@(posedge clk) disable iff (!pdn_n)
      $fell(reg_q[B_REF]) |-> !$past(ext_on));
endmodule

// File: rtl/cpwr_adc_timer.sv
module cpwr_adc_timer #(
   parameter int INIT_TICKS = 1059,
   parameter bit ASYNC_PDN  = 1'b1
) (
   input  logic clk,
   input  logic pdn_n,
   input  logic start,
   input  logic fs_tick,
   input  logic adc_on,
   output logic adc_valid
);
   if (INIT_TICKS < 1) begin : g_bad_len
      $error("cpwr_adc_timer: INIT_TICKS must be positive");
   end

   localparam int CNT_W = $clog2(INIT_TICKS + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(INIT_TICKS);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (start) cnt_d = LOAD;
      else if (fs_tick && (cnt_q != '0)) cnt_d = cnt_q - 1'b1;
   end

   if (ASYNC_PDN) begin : g_async
      always_ff @(posedge clk or negedge pdn_n) begin
         if (!pdn_n) cnt_q <= LOAD;
         else        cnt_q <= cnt_d;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!pdn_n) cnt_q <= LOAD;
         else        cnt_q <= cnt_d;
      end
   end

   assign adc_valid = adc_on && (cnt_q == '0);

   // R8: a start loads the full warm-up length
   assert_load_R8: assert property (@(posedge clk) disable iff (!pdn_n)
      start |=> (cnt_q == LOAD));
   // R8: data turns valid only on a sample tick
   assert_valid_tick_R8: assert property (@(posedge clk) disable iff (!pdn_n)
      $rose(adc_valid) |-> $past(fs_tick));
endmodule

// File: rtl/cpwr_en_gate.sv
module cpwr_en_gate #(
   parameter int N = 6
) (
   input  logic         pdn_n,
   input  logic [N-1:0] bits_in,
   output logic [N-1:0] en_out
);
   if (N < 1) begin : g_bad_n
      $error("cpwr_en_gate: N must be positive");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign en_out[i] = pdn_n & bits_in[i];
   end

   // R5: power-down removes every enable without a clock
   always_comb begin
      if (!pdn_n) begin
         assert_pdn_off_R5: assert (en_out == '0);
      end
   end
endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl
   import cpwr_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int REG_ADDR   = 0,
   parameter int INIT_TICKS = 1059,
   parameter bit ASYNC_PDN  = 1'b1
) (
   input  logic              clk,
   input  logic              pdn_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              ext_pwr_on,
   input  logic              fs_tick,
   output logic [7:0]        rd_data,
   output logic              en_ref,
   output logic              en_mono,
   output logic              en_spk,
   output logic              en_line,
   output logic              en_dac,
   output logic              en_adc,
   output logic              adc_valid,
   output logic              cfg_err,
   output logic              full_pd
);
   logic [BYTE_W-1:0] reg_q;
   logic              adc_start;
   logic [N_BLK-1:0]  en_bus;

   cpwr_regbank #(
      .ADDR_W   (ADDR_W),
      .REG_ADDR (REG_ADDR),
      .ASYNC_PDN(ASYNC_PDN)
   ) u_bank (
      .clk      (clk),
      .pdn_n    (pdn_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .ext_on   (ext_pwr_on),
      .reg_q    (reg_q),
      .err_q    (cfg_err),
      .adc_start(adc_start)
   );

   cpwr_en_gate #(.N(N_BLK)) u_gate (
      .pdn_n  (pdn_n),
      .bits_in(to_en_bus(reg_q)),
      .en_out (en_bus)
   );

   cpwr_adc_timer #(
      .INIT_TICKS(INIT_TICKS),
      .ASYNC_PDN (ASYNC_PDN)
   ) u_timer (
      .clk      (clk),
      .pdn_n    (pdn_n),
      .start    (adc_start),
      .fs_tick  (fs_tick),
      .adc_on   (en_bus[0]),
      .adc_valid(adc_valid)
   );

   assign rd_data = reg_q;
   assign en_adc  = en_bus[0];
   assign en_dac  = en_bus[1];
   assign en_line = en_bus[2];
   assign en_spk  = en_bus[3];
   assign en_mono = en_bus[4];
   assign en_ref  = en_bus[5];
   assign full_pd = !pdn_n || (!(|(reg_q & WR_MASK)) && !ext_pwr_on);

   // R11: the full power-down status never hides a live block
   assert_full_pd_R11: assert property (@(posedge clk) disable iff (!pdn_n)
      full_pd |-> (en_bus == '0));
endmodule

// File: tb/sim_codec_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_codec_pwr_ctrl;
   localparam int INIT = 1059;

   logic       clk = 1'b0;
   logic       pdn_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       ext_pwr_on = 1'b0;
   logic       fs_tick = 1'b0;
   logic [7:0] rd_data;
   logic en_ref, en_mono, en_spk, en_line, en_dac, en_adc;
   logic adc_valid, cfg_err, full_pd;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit tick_run = 1'b0;

   // reference model state
   logic [7:0] m_reg = '0;
   logic       m_err = 1'b0;
   int         m_cnt = INIT;

   always #2 clk = ~clk;

   codec_pwr_ctrl u0 (
      .clk(clk), .pdn_n(pdn_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ext_pwr_on(ext_pwr_on), .fs_tick(fs_tick),
      .rd_data(rd_data), .en_ref(en_ref), .en_mono(en_mono),
      .en_spk(en_spk), .en_line(en_line), .en_dac(en_dac), .en_adc(en_adc),
      .adc_valid(adc_valid), .cfg_err(cfg_err), .full_pd(full_pd)
   );

   always @(posedge clk or negedge pdn_n) begin
      if (!pdn_n) begin
         m_reg = '0;
         m_err = 1'b0;
         m_cnt = INIT;
      end else begin
         logic [7:0] nv;
         bit start;
         start = wr_en && wr_addr == 8'h00 && wr_data[0] && !m_reg[0];
         if (start) m_cnt = INIT;
         else if (fs_tick && m_cnt > 0) m_cnt = m_cnt - 1;
         if (wr_en && wr_addr == 8'h00) begin
            nv = wr_data & 8'h7D;
            if (m_reg[6] && !nv[6] && (((nv & 8'h3D) != 0) || ext_pwr_on)) begin
               nv[6] = 1'b1;
               m_err = 1'b1;
            end
            m_reg = nv;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // per-cycle comparison against the model
   task automatic cmp_all();
      logic [5:0] act_en, exp_en;
      bit exp_v, exp_pd;
      act_en = {en_ref, en_mono, en_spk, en_line, en_dac, en_adc};
      exp_en = pdn_n ? {m_reg[6], m_reg[5], m_reg[4], m_reg[3], m_reg[2], m_reg[0]} : 6'd0;
      exp_v  = pdn_n && m_reg[0] && (m_cnt == 0);
      exp_pd = !pdn_n || (((m_reg & 8'h7D) == 0) && !ext_pwr_on);
      chk(act_en == exp_en, "R2 enables", act_en, exp_en);
      chk(rd_data == m_reg, "R4 readback", rd_data, m_reg);
      chk(adc_valid == exp_v, "R8 adc_valid", adc_valid, exp_v);
      chk(cfg_err == m_err, "R6 cfg_err", cfg_err, m_err);
      chk(full_pd == exp_pd, "R11 full_pd", full_pd, exp_pd);
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc > 2) cmp_all();
   end

   initial begin : tick_gen
      int ph = 0;
      forever begin
         @(negedge clk);
         fs_tick = tick_run && (ph == 2);
         ph = (ph + 1) % 3;
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin : watchdog
      wait (cyc > 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      idle(3);
      #1 pdn_n = 1'b1;
      idle(1);
      // R1: state after release
      chk(rd_data == 8'h00 && !cfg_err && !adc_valid, "R1", rd_data, 0);
      chk({en_ref, en_mono, en_spk, en_line, en_dac, en_adc} == 0, "R1 enables", en_ref, 0);
      tick_run = 1'b1;
      // R2: reference alone
      wr(8'h00, 8'h40);
      chk(en_ref && !en_adc && !en_dac, "R2 ref only", rd_data, 8'h40);
      // R4: all ones, fixed zeros masked; starts warm-up
      wr(8'h00, 8'hFF);
      chk(rd_data == 8'h7D, "R4 masked bits", rd_data, 8'h7D);
      chk(en_spk && en_line && en_mono && en_dac && en_adc, "R2 all on", rd_data, 8'h7D);
      // R3: foreign address
      wr(8'h01, 8'h00);
      chk(rd_data == 8'h7D && en_ref, "R3 other addr", rd_data, 8'h7D);
      // R6: clear ref while others on
      wr(8'h00, 8'h3D);
      chk(rd_data == 8'h7D && cfg_err, "R6 refused clear", rd_data, 8'h7D);
      // R8: before and after the tick count
      idle(2900);
      chk(!adc_valid, "R8 still warming", adc_valid, 0);
      idle(300);
      chk(adc_valid, "R8 warm-up done", adc_valid, 1);
      // R10: rewrite while set
      wr(8'h00, 8'h7D);
      chk(adc_valid, "R10 no retrigger", adc_valid, 1);
      // R9: clear, then restart partway
      wr(8'h00, 8'h7C);
      chk(!adc_valid, "R9 drop", adc_valid, 0);
      wr(8'h00, 8'h7D);
      idle(1500);
      wr(8'h00, 8'h7C);
      wr(8'h00, 8'h7D);
      idle(3000);
      chk(!adc_valid, "R9 restarted count", adc_valid, 0);
      idle(300);
      chk(adc_valid, "R9 restart completes", adc_valid, 1);
      // R6: outside block holds the reference
      @(negedge clk); ext_pwr_on = 1'b1;
      wr(8'h00, 8'h00);
      chk(rd_data == 8'h40 && cfg_err, "R6 held by ext", rd_data, 8'h40);
      chk(!full_pd, "R11 ext on", full_pd, 0);
      @(negedge clk); ext_pwr_on = 1'b0;
      wr(8'h00, 8'h00);
      chk(rd_data == 8'h00, "R7 honoured clear", rd_data, 8'h00);
      chk(full_pd && cfg_err, "R11 full pd", full_pd, 1);
      // R5: power-down override between edges
      wr(8'h00, 8'h64);
      chk(en_ref && en_mono && en_dac, "R2 playback", rd_data, 8'h64);
      #1 pdn_n = 1'b0;
      #0.5;
      chk({en_ref, en_mono, en_dac} == 0, "R5 immediate off", {en_ref, en_mono, en_dac}, 0);
      chk(full_pd, "R11 pdn", full_pd, 1);
      idle(3);
      #1 pdn_n = 1'b1;
      idle(2);
      chk(rd_data == 8'h00 && !cfg_err, "R5 cleared", rd_data, 0);
      tick_run = 1'b0;
      idle(5);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule